// File: doc/BRIEF.md
# Three-Wire Temperature Sensor Master

This block is the master side of a three-wire serial link to a digital temperature sensor. The link has an enable line that frames each transfer, a serial clock that idles high, and one data line shared by both ends. The master drives the data line for command bits. It then lets go of the line so the sensor can return its answer on the same wire.

The first host `start` after reset runs three transfers in a fixed order. The first writes a configuration command and its argument, which put the sensor into continuous conversion. The second tells the sensor to begin converting. The third reads the temperature. Every later `start` runs only the read transfer. The block reports each read through `temp_o`, a 9-bit two's complement value in half-degree steps, together with a strobe that lasts one cycle. The serial clock comes from the system clock through a divider that is set by a parameter. Between transfers, the enable line stays low for at least a set number of cycles. A further wait follows the start-conversion command.

Top module: `thermo3w_master`

## Requirements
- R1: After reset, `tw_en_o`=0, `tw_clk_o`=1, `tw_dq_oe_o`=0, `busy_o`=0 and `valid_o`=0.
- R2: The first `start_i` after reset produces three frames in this order, with every byte sent least significant bit first. The first frame sends 0xC0 then 0x00, which is 16 bits with no response. The second frame sends 0xEE, which is 8 bits with no response. The third frame sends 0xAA (8 bits) and then takes 9 response bits.
- R3: While `tw_en_o` is low, `tw_clk_o` is high. Once `tw_en_o` rises, the clock stays high for `DIV` cycles before the first falling edge. Every bit then has a low half of `DIV` cycles followed by a high half of `DIV` cycles.
- R4: The master changes `tw_dq_o` only at a falling clock edge, so the value is stable across each rising edge.
- R5: The master samples `tw_dq_i` at each rising edge of a response bit. The first response bit becomes bit 0 of `temp_o` and the ninth becomes bit 8, giving a two's complement value in half-degree steps.
- R6: `tw_dq_oe_o` is high only inside a frame. It rises together with `tw_en_o` and falls at the falling edge that ends the last command bit, so it is low for every response bit.
- R7: Between the end of one frame and the start of the next, `tw_en_o` stays low for at least `GAP_CYC` cycles. Between the start-conversion frame and the first read frame it stays low for at least `GAP_CYC+CONV_WAIT` cycles.
- R8: `valid_o` is high for exactly one cycle when the read frame completes. `temp_o` changes only in that cycle.
- R9: Once the sensor has been configured, each later `start_i` produces exactly one read frame (0xAA followed by 9 response bits).
- R10: `busy_o` rises in the cycle after an accepted `start_i` and stays high until the trailing gap has ended. `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while the block is idle |
| busy_o | output | 1 | Sequence in progress |
| valid_o | output | 1 | One-cycle strobe marking a new temperature |
| temp_o | output | TEMP_W | Last temperature read, two's complement, half-degree steps |
| tw_en_o | output | 1 | Transfer enable line, high for the length of a frame |
| tw_clk_o | output | 1 | Serial clock, idles high |
| tw_dq_o | output | 1 | Data value the master drives |
| tw_dq_oe_o | output | 1 | Master drive enable for the shared data line |
| tw_dq_i | input | 1 | Value seen on the shared data line |

## Verification
A bad bit index or command shift register shows up on the pins within one frame. When `tw_en_o` falls, the frame has the wrong length, the wrong command bits or a drive enable that lasts too long. A wrong configured flag shows on the next `start_i`: either the configuration frames run again, or the read is issued with no configuration before it. A fault on the receive path, such as a wrong sample edge or the bits shifted in the wrong order, corrupts `temp_o` at the strobe of the read in which it happens. Because the bench returns all 512 possible response codes, it reaches every bit position and both signs.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int TX_MAX = 16;
  localparam logic [7:0] OP_SETUP     = 8'hC0;
  localparam logic [7:0] OP_SETUP_ARG = 8'h00;
  localparam logic [7:0] OP_CONVERT   = 8'hEE;
  localparam logic [7:0] OP_FETCH     = 8'hAA;

  typedef enum logic [1:0] {K_SETUP, K_CONVERT, K_FETCH} frame_e;
  typedef enum logic [1:0] {E_IDLE, E_LEAD, E_LO, E_HI} eng_e;
  typedef enum logic [2:0] {
    Q_IDLE, Q_SETUP, Q_WSETUP, Q_CONV, Q_WCONV, Q_FETCH, Q_TAIL
  } seq_e;
endpackage

// File: rtl/tw_tick.sv
module tw_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CW'(DIV - 1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tw_frame.sv
module tw_frame import tw_pkg::*; #(
  parameter int DIV   = 4,
  parameter int RX_W  = 9,
  parameter int BIT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [TX_MAX-1:0] tx_data,
  input  logic [BIT_W-1:0]  tx_n,
  input  logic [BIT_W-1:0]  rx_n,
  input  logic              dq_i,
  output logic              bus_en,
  output logic              bus_clk,
  output logic              dq_o,
  output logic              dq_oe,
  output logic              done,
  output logic [RX_W-1:0]   rx_data
);
  eng_e              st_q, st_d;
  logic [BIT_W-1:0]  idx_q, idx_d, last_q, last_d, txn_q, txn_d;
  logic [TX_MAX-1:0] sh_q, sh_d;
  logic [RX_W-1:0]   rx_q, rx_d;
  logic              done_q, done_d;
  logic              tick;

  tw_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st_q != E_IDLE),
    .tick (tick)
  );

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    last_d = last_q;
    txn_d  = txn_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    case (st_q)
      E_IDLE: if (go) begin
        st_d   = E_LEAD;
        idx_d  = '0;
        last_d = tx_n + rx_n - BIT_W'(1);
        txn_d  = tx_n;
        sh_d   = tx_data;
      end
      E_LEAD: if (tick) st_d = E_LO;
      E_LO: if (tick) begin
        st_d = E_HI;
        if (idx_q >= txn_q) rx_d = {dq_i, rx_q[RX_W-1:1]};
      end
      E_HI: if (tick) begin
        if (idx_q < txn_q) sh_d = sh_q >> 1;
        if (idx_q == last_q) begin
          st_d   = E_IDLE;
          done_d = 1'b1;
        end else begin
          st_d  = E_LO;
          idx_d = idx_q + BIT_W'(1);
        end
      end
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      idx_q  <= '0;
      last_q <= '0;
      txn_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      last_q <= last_d;
      txn_q  <= txn_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  assign bus_en  = (st_q != E_IDLE);
  assign bus_clk = (st_q != E_LO);
  assign dq_o    = sh_q[0];
  assign dq_oe   = bus_en && (idx_q < txn_q);
  assign done    = done_q;
  assign rx_data = rx_q;
endmodule

// File: rtl/thermo3w_master.sv
module thermo3w_master import tw_pkg::*; #(
  parameter int DIV       = 4,
  parameter int GAP_CYC   = 8,
  parameter int CONV_WAIT = 20,
  parameter int TEMP_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [TEMP_W-1:0] temp_o,
  output logic              tw_en_o,
  output logic              tw_clk_o,
  output logic              tw_dq_o,
  output logic              tw_dq_oe_o,
  input  logic              tw_dq_i
);
  localparam int BIT_W  = $clog2(TX_MAX + TEMP_W + 1);
  localparam int WAIT_W = $clog2(GAP_CYC + CONV_WAIT + 1);

  logic [1:0] rsync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  seq_e              st_q, st_d;
  logic [WAIT_W-1:0] w_q, w_d;
  logic              cfg_q, cfg_d, valid_q, valid_d;
  logic [TEMP_W-1:0] temp_q, temp_d;
  logic              go, fr_done;
  frame_e            kind;
  logic [TX_MAX-1:0] tx_data;
  logic [BIT_W-1:0]  tx_n, rx_n;
  logic [TEMP_W-1:0] rx_data;

  always_comb begin
    st_d    = st_q;
    w_d     = w_q;
    cfg_d   = cfg_q;
    temp_d  = temp_q;
    valid_d = 1'b0;
    go      = 1'b0;
    kind    = K_FETCH;
    case (st_q)
      Q_IDLE: if (start_i) begin
        go = 1'b1;
        if (cfg_q) begin
          kind = K_FETCH;
          st_d = Q_FETCH;
        end else begin
          kind = K_SETUP;
          st_d = Q_SETUP;
        end
      end
      Q_SETUP: if (fr_done) begin
        st_d = Q_WSETUP;
        w_d  = WAIT_W'(GAP_CYC);
      end
      Q_WSETUP: if (w_q == '0) begin
        go   = 1'b1;
        kind = K_CONVERT;
        st_d = Q_CONV;
      end else w_d = w_q - WAIT_W'(1);
      Q_CONV: if (fr_done) begin
        st_d  = Q_WCONV;
        w_d   = WAIT_W'(GAP_CYC + CONV_WAIT);
        cfg_d = 1'b1;
      end
      Q_WCONV: if (w_q == '0) begin
        go   = 1'b1;
        kind = K_FETCH;
        st_d = Q_FETCH;
      end else w_d = w_q - WAIT_W'(1);
      Q_FETCH: if (fr_done) begin
        temp_d  = rx_data;
        valid_d = 1'b1;
        st_d    = Q_TAIL;
        w_d     = WAIT_W'(GAP_CYC);
      end
      Q_TAIL: if (w_q == '0) st_d = Q_IDLE;
              else w_d = w_q - WAIT_W'(1);
      default: st_d = Q_IDLE;
    endcase
  end

  always_comb begin
    case (kind)
      K_SETUP: begin
        tx_data = {OP_SETUP_ARG, OP_SETUP};
        tx_n    = BIT_W'(16);
        rx_n    = '0;
      end
      K_CONVERT: begin
        tx_data = {8'h00, OP_CONVERT};
        tx_n    = BIT_W'(8);
        rx_n    = '0;
      end
      default: begin
        tx_data = {8'h00, OP_FETCH};
        tx_n    = BIT_W'(8);
        rx_n    = BIT_W'(TEMP_W);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q    <= Q_IDLE;
      w_q     <= '0;
      cfg_q   <= 1'b0;
      temp_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      w_q     <= w_d;
      cfg_q   <= cfg_d;
      temp_q  <= temp_d;
      valid_q <= valid_d;
    end
  end

  tw_frame #(.DIV(DIV), .RX_W(TEMP_W), .BIT_W(BIT_W)) u_frame (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .go     (go),
    .tx_data(tx_data),
    .tx_n   (tx_n),
    .rx_n   (rx_n),
    .dq_i   (tw_dq_i),
    .bus_en (tw_en_o),
    .bus_clk(tw_clk_o),
    .dq_o   (tw_dq_o),
    .dq_oe  (tw_dq_oe_o),
    .done   (fr_done),
    .rx_data(rx_data)
  );

  assign busy_o  = (st_q != Q_IDLE);
  assign valid_o = valid_q;
  assign temp_o  = temp_q;
endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
  parameter int GAP_CYC = 8,
  parameter int TEMP_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              valid_o,
  input logic [TEMP_W-1:0] temp_o,
  input logic              tw_en_o,
  input logic              tw_clk_o,
  input logic              tw_dq_o,
  input logic              tw_dq_oe_o
);
  localparam int LW = $clog2(GAP_CYC + 2);

  logic [LW-1:0] low_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (tw_en_o) begin
        low_q  <= '0;
        seen_q <= 1'b1;
      end else if (low_q != LW'(GAP_CYC)) begin
        low_q <= low_q + LW'(1);
      end
    end
  end

  p_idle_clk_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tw_en_o |-> tw_clk_o);
  p_lead_clk_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tw_en_o) |-> tw_clk_o);
  p_dq_stable_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_clk_o && $past(tw_clk_o) && tw_dq_oe_o && $past(tw_dq_oe_o)) |-> $stable(tw_dq_o));
  p_oe_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tw_dq_oe_o |-> tw_en_o);
  p_oe_rise_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tw_dq_oe_o) |-> $rose(tw_en_o));
  p_min_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tw_en_o) && seen_q) |-> (low_q >= LW'(GAP_CYC)));
  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_temp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(temp_o));
  p_valid_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> busy_o);
endmodule

bind thermo3w_master tw_checker #(.GAP_CYC(GAP_CYC), .TEMP_W(TEMP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_o    (busy_o),
  .valid_o   (valid_o),
  .temp_o    (temp_o),
  .tw_en_o   (tw_en_o),
  .tw_clk_o  (tw_clk_o),
  .tw_dq_o   (tw_dq_o),
  .tw_dq_oe_o(tw_dq_oe_o)
);

// File: tb/sim_thermo3w_master.sv
`timescale 1ns/1ps
module sim_thermo3w_master;
  localparam int DIV = 4, GAP = 8, CONVW = 20, TW = 9, TCK = 10;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic busy_o, valid_o, tw_en_o, tw_clk_o, tw_dq_o, tw_dq_oe_o, tw_dq_i;
  logic [TW-1:0] temp_o;

  always #(TCK/2) clk = ~clk;

  thermo3w_master #(.DIV(DIV), .GAP_CYC(GAP), .CONV_WAIT(CONVW), .TEMP_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .valid_o(valid_o),
    .temp_o(temp_o), .tw_en_o(tw_en_o), .tw_clk_o(tw_clk_o), .tw_dq_o(tw_dq_o),
    .tw_dq_oe_o(tw_dq_oe_o), .tw_dq_i(tw_dq_i)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sensor model: records frames, answers a fetch command on the shared line
  logic [TW-1:0] resp = '0;
  logic s_drv = 1'b0, s_bit = 1'b0;
  int bitc = 0, txn = 0, nf = 0;
  logic [31:0] rec = '0;
  int f_txn[0:599], f_tot[0:599];
  logic [31:0] f_rec[0:599];
  time f_start[0:599], f_end[0:599];
  time t_en = 0, t_fall = 0;
  int bad_half = 0, bad_lead = 0, bad_dq = 0, bad_oe = 0, halves = 0;
  logic p_oe = 1'b0, p_dq = 1'b0;

  assign tw_dq_i = tw_dq_oe_o ? tw_dq_o : (s_drv ? s_bit : 1'b1);

  always @(posedge tw_en_o) begin
    bitc = 0; txn = 0; rec = '0; s_drv = 1'b0;
    t_en = $time;
    f_start[nf] = $time;
  end

  always @(negedge tw_en_o) begin
    f_rec[nf] = rec; f_txn[nf] = txn; f_tot[nf] = bitc; f_end[nf] = $time;
    nf++;
    s_drv = 1'b0;
  end

  always @(posedge tw_clk_o) if (tw_en_o) begin
    if (tw_dq_oe_o) begin rec[bitc] = tw_dq_o; txn++; end
    bitc++;
    halves++;
    if ($time - t_fall != DIV*TCK) bad_half++;
  end

  always @(negedge tw_clk_o) if (tw_en_o) begin
    t_fall = $time;
    if (bitc == 0 && ($time - t_en != DIV*TCK)) bad_lead++;
    if (txn == 8 && bitc >= 8 && bitc < 8 + TW && rec[7:0] == 8'hAA) begin
      s_drv = 1'b1;
      s_bit = resp[bitc-8];
    end
  end

  always @(negedge clk) begin
    if (p_oe && tw_dq_oe_o && (tw_dq_o != p_dq) && tw_clk_o) bad_dq++;
    if (!tw_en_o && tw_dq_oe_o) bad_oe++;
    p_oe = tw_dq_oe_o;
    p_dq = tw_dq_o;
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_valid();
    int n = 0;
    while (!valid_o && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 3000) begin @(negedge clk); n++; end
  endtask

  initial begin
    resp = 9'h1A5;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!tw_en_o && tw_clk_o && !tw_dq_oe_o, "R1 bus idle", {tw_en_o, tw_clk_o, tw_dq_oe_o}, 3'b010);
    chk(!busy_o && !valid_o, "R1 host idle", {busy_o, valid_o}, 0);

    pulse_start();
    chk(busy_o, "R10 busy after start", busy_o, 1);
    repeat (50) @(negedge clk);
    pulse_start();  // R10: ignored while busy
    wait_valid();
    chk(valid_o, "R8 valid seen", valid_o, 1);
    chk(temp_o == 9'h1A5, "R5 first temperature", temp_o, 9'h1A5);
    @(negedge clk);
    chk(!valid_o, "R8 valid one cycle", valid_o, 0);
    wait_idle();
    chk(nf == 3, "R10 start while busy ignored", nf, 3);
    chk(f_txn[0] == 16 && f_tot[0] == 16 && f_rec[0][15:0] == 16'h00C0,
        "R2 setup frame", f_rec[0][15:0], 16'h00C0);
    chk(f_txn[1] == 8 && f_tot[1] == 8 && f_rec[1][7:0] == 8'hEE,
        "R2 convert frame", f_rec[1][7:0], 8'hEE);
    chk(f_txn[2] == 8 && f_tot[2] == 8 + TW && f_rec[2][7:0] == 8'hAA,
        "R2 fetch frame", f_tot[2], 8 + TW);
    chk(f_start[2] - f_end[1] >= (GAP + CONVW) * TCK, "R7 convert wait",
        int'(f_start[2] - f_end[1]), (GAP + CONVW) * TCK);

    for (int v = 0; v < (1 << TW); v++) begin
      logic [TW-1:0] prev;
      int nf0;
      prev = temp_o;
      nf0 = nf;
      resp = TW'(v);
      pulse_start();
      repeat (20) @(negedge clk);
      chk(temp_o == prev, "R8 temp held during read", temp_o, prev);
      wait_valid();
      chk(temp_o == TW'(v), "R5 sweep temperature", temp_o, v);
      wait_idle();
      chk(nf == nf0 + 1 && f_txn[nf-1] == 8 && f_tot[nf-1] == 8 + TW && f_rec[nf-1][7:0] == 8'hAA,
          "R9 read-only frame", nf - nf0, 1);
    end

    begin
      int badgap = 0;
      for (int k = 1; k < nf; k++)
        if (f_start[k] - f_end[k-1] < GAP * TCK) badgap++;
      chk(badgap == 0, "R7 minimum gap", badgap, 0);
    end
    chk(bad_half == 0 && halves > 0, "R3 half period", bad_half, 0);
    chk(bad_lead == 0, "R3 lead time", bad_lead, 0);
    chk(bad_dq == 0, "R4 data change on clock low", bad_dq, 0);
    chk(bad_oe == 0, "R6 no drive between frames", bad_oe, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(190000 * TCK);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule